// File: doc/BRIEF.md
# Non-Cacheable Address Region Decoder

This block holds a compact set of cache-configuration registers and uses them to decide whether a 32-bit physical address may be cached. Software reaches the registers one byte at a time. It puts an 8-bit index on the configuration port and either writes a byte or reads one back combinationally.

Two 8-bit control registers sit at fixed indices. Four region descriptors, each three bytes long, sit at consecutive indices after them. Each descriptor gives a start address at 4 KB granularity and a 4-bit size code.

On the decode side, an address enters every cycle. One clock later a single flag reports whether that address falls inside any enabled region or inside one of two fixed legacy windows. Control bits other than the two window enables are only stored and read back; they have no effect on the decode.

Top module: `nc_region_decoder`

## Requirements
- R1: After reset every register reads 0x00 and the non-cacheable flag is low for every address.
- R2: Control register A is at index 0xC0 and control register B at 0xC1. Descriptor k (k = 0..3) occupies indices 0xC4+3k, 0xC5+3k and 0xC6+3k, in that byte order. Every defined byte reads back the value last written to it.
- R3: A read from any index other than 0xC0, 0xC1 or 0xC4..0xCF returns 0xFF. A write to such an index changes no register and no decode result.
- R4: All 8 bits of control register A are stored. In control register B only bit 0 is stored; bits 7..1 ignore writes and read as 0.
- R5: Descriptor byte 0 supplies start-address bits 31..24 and byte 1 supplies bits 23..16. Byte 2 supplies bits 15..12 in its upper nibble and the size code in its lower nibble.
- R6: Size code 0 disables the region, so the region never matches.
- R7: A size code n from 1 to 14 covers 2^(n+11) bytes. An address matches when its bits 31..(n+11) equal the same bits of the start address. Start bits below that boundary are ignored, so no alignment check is made.
- R8: Size code 15 matches every address.
- R9: With control register A bit 0 set, any address whose bits 19..16 are all zero is non-cacheable.
- R10: With control register A bit 1 set, addresses 0x000A0000 through 0x000FFFFF are non-cacheable.
- R11: The flag is the OR of the four region matches and the two window matches. It is registered, and reflects the address presented one clock earlier.
- R12: A byte written at a clock edge already governs the decode of the address captured at the following edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_idx | input | 8 | Configuration byte index |
| cfg_wr_en | input | 1 | Write strobe for the byte at cfg_idx |
| cfg_wdata | input | 8 | Byte to write |
| cfg_rdata | output | 8 | Byte read from cfg_idx (combinational) |
| addr_in | input | 32 | Physical address to classify |
| nc_flag | output | 1 | Address presented last cycle is non-cacheable |

## Verification
Configuration reads have no latency. The bench checks cfg_rdata a short delay after setting the index, with no clock edge in between.

The decode result is due exactly one rising edge after an address is applied. The driver applies each address on a falling edge and pushes its expected flag into a queue. The monitor pops one entry at every rising edge and compares a quarter period later, so a result arriving one cycle early or late breaks the comparison.

For the write-to-decode path, an address is applied on the same falling edge at which the write strobe drops. This checks that the new byte governs the very next decode.

// File: rtl/ncr_pkg.sv
package ncr_pkg;
    localparam int ADDR_W     = 32;
    localparam int IDX_W      = 8;
    localparam int BYTE_W     = 8;
    localparam int N_REGION   = 4;
    localparam int DESC_BYTES = 3;
    localparam int DESC_W     = DESC_BYTES * BYTE_W;
    localparam int PAGE_SHIFT = 12;
    localparam int CODE_W     = 4;

    localparam logic [IDX_W-1:0] IDX_CTL_A     = 8'hC0;
    localparam logic [IDX_W-1:0] IDX_CTL_B     = 8'hC1;
    localparam int               IDX_DESC_BASE = 8'hC4;

    localparam logic [BYTE_W-1:0] RD_UNDEF = 8'hFF;

    localparam logic [CODE_W-1:0] CODE_OFF  = 4'd0;
    localparam logic [CODE_W-1:0] CODE_FULL = 4'd15;
endpackage

// File: rtl/ncr_cfg_regs.sv
module ncr_cfg_regs
    import ncr_pkg::*;
#(
    parameter int NREG = N_REGION
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic [IDX_W-1:0]       cfg_idx,
    input  logic                   cfg_wr_en,
    input  logic [BYTE_W-1:0]      cfg_wdata,
    output logic [BYTE_W-1:0]      cfg_rdata,
    output logic [BYTE_W-1:0]      ctl_a,
    output logic [NREG*DESC_W-1:0] desc_flat
);
    logic [BYTE_W-1:0] ctl_a_q;
    logic              ctl_b_q;
    logic [NREG-1:0][DESC_BYTES-1:0][BYTE_W-1:0] desc_q;

    function automatic logic [IDX_W-1:0] byte_idx(input int k, input int j);
        return IDX_W'(IDX_DESC_BASE + DESC_BYTES * k + j);
    endfunction

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctl_a_q <= '0;
            ctl_b_q <= 1'b0;
            desc_q  <= '0;
        end else if (cfg_wr_en) begin
            if (cfg_idx == IDX_CTL_A) ctl_a_q <= cfg_wdata;
            if (cfg_idx == IDX_CTL_B) ctl_b_q <= cfg_wdata[0];
            for (int k = 0; k < NREG; k++) begin
                for (int j = 0; j < DESC_BYTES; j++) begin
                    if (cfg_idx == byte_idx(k, j)) desc_q[k][j] <= cfg_wdata;
                end
            end
        end
    end

    always_comb begin
        cfg_rdata = RD_UNDEF;
        if (cfg_idx == IDX_CTL_A) cfg_rdata = ctl_a_q;
        if (cfg_idx == IDX_CTL_B) cfg_rdata = {{(BYTE_W-1){1'b0}}, ctl_b_q};
        for (int k = 0; k < NREG; k++) begin
            for (int j = 0; j < DESC_BYTES; j++) begin
                if (cfg_idx == byte_idx(k, j)) cfg_rdata = desc_q[k][j];
            end
        end
    end

    assign ctl_a = ctl_a_q;

    // byte 0 lands in the most significant position of each descriptor
    for (genvar k = 0; k < NREG; k++) begin : g_pack
        assign desc_flat[k*DESC_W +: DESC_W] = {desc_q[k][0], desc_q[k][1], desc_q[k][2]};
    end
endmodule

// File: rtl/ncr_region_match.sv
module ncr_region_match
    import ncr_pkg::*;
#(
    parameter int AW = ADDR_W,
    parameter int PS = PAGE_SHIFT
) (
    input  logic [DESC_W-1:0] desc,
    input  logic [AW-1:0]     addr,
    output logic              hit
);
    localparam int START_W = AW - PS;

    logic [CODE_W-1:0] code;
    logic [AW-1:0]     start;
    logic [AW-1:0]     care;

    assign code  = desc[CODE_W-1:0];
    assign start = {desc[DESC_W-1 -: START_W], {PS{1'b0}}};

    // code n covers 2^(n+PS-1) bytes: only bits at or above that boundary compare
    always_comb begin
        for (int b = 0; b < AW; b++) begin
            care[b] = (code != CODE_FULL) && (b >= int'(code) + PS - 1);
        end
    end

    assign hit = (code != CODE_OFF) && (((addr ^ start) & care) == '0);
endmodule

// File: rtl/ncr_fixed_windows.sv
module ncr_fixed_windows
    import ncr_pkg::*;
#(
    parameter int               AW       = ADDR_W,
    parameter int               MB_SHIFT = 20,
    parameter int               BLK_BITS = 4,
    parameter logic [19:0]      HOLE_LO  = 20'hA0000
) (
    input  logic [1:0]    win_en,
    input  logic [AW-1:0] addr,
    output logic          hit
);
    logic low_blk_hit;
    logic hole_hit;

    assign low_blk_hit = win_en[0] && (addr[MB_SHIFT-1 -: BLK_BITS] == '0);
    assign hole_hit    = win_en[1] && (addr[AW-1:MB_SHIFT] == '0)
                         && (addr[MB_SHIFT-1:0] >= HOLE_LO);
    assign hit = low_blk_hit || hole_hit;
endmodule

// File: rtl/nc_region_decoder.sv
module nc_region_decoder
    import ncr_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic [IDX_W-1:0]  cfg_idx,
    input  logic              cfg_wr_en,
    input  logic [BYTE_W-1:0] cfg_wdata,
    output logic [BYTE_W-1:0] cfg_rdata,
    input  logic [ADDR_W-1:0] addr_in,
    output logic              nc_flag
);
    logic [BYTE_W-1:0]          ctl_a;
    logic [N_REGION*DESC_W-1:0] desc_flat;
    logic [N_REGION-1:0]        region_hit;
    logic                       window_hit;
    logic                       nc_d;

    ncr_cfg_regs #(.NREG(N_REGION)) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .cfg_idx   (cfg_idx),
        .cfg_wr_en (cfg_wr_en),
        .cfg_wdata (cfg_wdata),
        .cfg_rdata (cfg_rdata),
        .ctl_a     (ctl_a),
        .desc_flat (desc_flat)
    );

    for (genvar k = 0; k < N_REGION; k++) begin : g_region
        ncr_region_match #(.AW(ADDR_W), .PS(PAGE_SHIFT)) u_match (
            .desc (desc_flat[k*DESC_W +: DESC_W]),
            .addr (addr_in),
            .hit  (region_hit[k])
        );
    end

    ncr_fixed_windows #(.AW(ADDR_W)) u_win (
        .win_en (ctl_a[1:0]),
        .addr   (addr_in),
        .hit    (window_hit)
    );

    assign nc_d = (|region_hit) || window_hit;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) nc_flag <= 1'b0;
        else        nc_flag <= nc_d;
    end
endmodule

// File: rtl/ncr_decoder_chk.sv
module ncr_decoder_chk
    import ncr_pkg::*;
(
    input logic                       clk,
    input logic                       rst_n,
    input logic [IDX_W-1:0]           cfg_idx,
    input logic                       cfg_wr_en,
    input logic [BYTE_W-1:0]          cfg_rdata,
    input logic [ADDR_W-1:0]          addr_in,
    input logic                       nc_flag,
    input logic [BYTE_W-1:0]          ctl_a,
    input logic [N_REGION*DESC_W-1:0] desc_flat
);
    logic all_off;
    logic any_full;
    logic idx_undef;

    always_comb begin
        all_off  = 1'b1;
        any_full = 1'b0;
        for (int k = 0; k < N_REGION; k++) begin
            if (desc_flat[k*DESC_W +: CODE_W] != CODE_OFF)  all_off  = 1'b0;
            if (desc_flat[k*DESC_W +: CODE_W] == CODE_FULL) any_full = 1'b1;
        end
    end

    assign idx_undef = (cfg_idx < IDX_CTL_A) || (cfg_idx > 8'hCF)
                       || (cfg_idx == 8'hC2) || (cfg_idx == 8'hC3);

    // R6
    all_disabled_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (all_off && ctl_a[1:0] == 2'b00) |=> !nc_flag);

    // R8
    full_space_chk: assert property (@(posedge clk) disable iff (!rst_n)
        any_full |=> nc_flag);

    // R9
    low_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl_a[0] && addr_in[19:16] == 4'h0) |=> nc_flag);

    // R10
    hole_window_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl_a[1] && addr_in >= 32'h000A0000 && addr_in < 32'h00100000) |=> nc_flag);

    // R3
    undef_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
        idx_undef |-> cfg_rdata == RD_UNDEF);

    // R3
    undef_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_wr_en && idx_undef) |=> $stable({ctl_a, desc_flat}));

    // R4
    reserved_bits_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_idx == IDX_CTL_B) |-> cfg_rdata[7:1] == 7'd0);
endmodule

bind nc_region_decoder ncr_decoder_chk chk_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .cfg_idx   (cfg_idx),
    .cfg_wr_en (cfg_wr_en),
    .cfg_rdata (cfg_rdata),
    .addr_in   (addr_in),
    .nc_flag   (nc_flag),
    .ctl_a     (ctl_a),
    .desc_flat (desc_flat)
);

// File: tb/nc_region_decoder_test.sv
module nc_region_decoder_test;
    localparam int PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [7:0]  cfg_idx = 8'h00;
    logic        cfg_wr_en = 1'b0;
    logic [7:0]  cfg_wdata = 8'h00;
    logic [7:0]  cfg_rdata;
    logic [31:0] addr_in = 32'h0;
    logic        nc_flag;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 1'b0;

    typedef struct {
        logic [31:0] addr;
        logic        exp;
        string       tag;
    } sb_item_t;

    sb_item_t sb_q[$];

    nc_region_decoder uut (
        .clk       (clk),
        .rst_n     (rst_n),
        .cfg_idx   (cfg_idx),
        .cfg_wr_en (cfg_wr_en),
        .cfg_wdata (cfg_wdata),
        .cfg_rdata (cfg_rdata),
        .addr_in   (addr_in),
        .nc_flag   (nc_flag)
    );

    always #(PERIOD/2) clk = ~clk;

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    endtask

    // monitor: one expected result is due per rising edge
    always @(posedge clk) begin
        if (sb_q.size() > 0) begin
            sb_item_t it;
            it = sb_q.pop_front();
            #(PERIOD/4);
            n_checks++;
            if (nc_flag !== it.exp) begin
                n_fail++;
                $display("FAIL %s addr=%h actual=%b expected=%b", it.tag, it.addr, nc_flag, it.exp);
            end
        end
    end

    // driver tasks: each starts at a falling edge and returns at the next one
    task automatic probe(input logic [31:0] a, input logic e, input string tag);
        sb_item_t it;
        addr_in = a;
        it.addr = a;
        it.exp  = e;
        it.tag  = tag;
        sb_q.push_back(it);
        @(negedge clk);
    endtask

    task automatic wr(input logic [7:0] idx, input logic [7:0] data);
        cfg_idx   = idx;
        cfg_wdata = data;
        cfg_wr_en = 1'b1;
        @(negedge clk);
        cfg_wr_en = 1'b0;
    endtask

    task automatic rd_check(input logic [7:0] idx, input logic [7:0] exp, input string tag);
        cfg_idx = idx;
        #1;
        n_checks++;
        if (cfg_rdata !== exp) begin
            n_fail++;
            $display("FAIL %s idx=%h actual=%h expected=%h", tag, idx, cfg_rdata, exp);
        end
    endtask

    initial begin
        #(PERIOD * 200000);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog actual=running expected=finished");
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1: reset state
        n_checks++;
        if (nc_flag !== 1'b0) begin
            n_fail++;
            $display("FAIL R1 nc_flag actual=%b expected=0", nc_flag);
        end
        rd_check(8'hC0, 8'h00, "R1");
        rd_check(8'hC1, 8'h00, "R1");
        for (int i = 8'hC4; i <= 8'hCF; i++) rd_check(8'(i), 8'h00, "R1");
        probe(32'h00000000, 1'b0, "R1");
        probe(32'h000A0000, 1'b0, "R1");
        probe(32'hFFFFFFFF, 1'b0, "R1");

        // R3: undefined indices
        rd_check(8'hC2, 8'hFF, "R3");
        rd_check(8'hC3, 8'hFF, "R3");
        rd_check(8'h00, 8'hFF, "R3");
        rd_check(8'hD0, 8'hFF, "R3");
        wr(8'hC2, 8'h55);
        wr(8'hD0, 8'h0F);
        wr(8'hBF, 8'h03);
        rd_check(8'hC2, 8'hFF, "R3");
        rd_check(8'hC0, 8'h00, "R3");
        for (int i = 8'hC4; i <= 8'hCF; i++) rd_check(8'(i), 8'h00, "R3");
        probe(32'h00000000, 1'b0, "R3");

        // R4: reserved bits and full storage of control register A
        wr(8'hC1, 8'hFF);
        rd_check(8'hC1, 8'h01, "R4");
        wr(8'hC1, 8'hFE);
        rd_check(8'hC1, 8'h00, "R4");
        wr(8'hC0, 8'hFC);
        rd_check(8'hC0, 8'hFC, "R4");
        probe(32'h00000000, 1'b0, "R4");
        wr(8'hC0, 8'h00);

        // R2 / R5 / R7: region 0, 16 KB at 0x12344000
        wr(8'hC4, 8'h12);
        wr(8'hC5, 8'h34);
        wr(8'hC6, 8'h43);
        rd_check(8'hC4, 8'h12, "R2");
        rd_check(8'hC5, 8'h34, "R2");
        rd_check(8'hC6, 8'h43, "R2");
        probe(32'h12344000, 1'b1, "R7");
        probe(32'h12347FFF, 1'b1, "R7");
        probe(32'h12348000, 1'b0, "R7");
        probe(32'h12343FFF, 1'b0, "R7");

        // R12 / R6: disable then re-enable, probing right after each write
        wr(8'hC6, 8'h40);
        probe(32'h12344000, 1'b0, "R12");
        probe(32'h12345000, 1'b0, "R6");
        wr(8'hC6, 8'h43);
        probe(32'h12344000, 1'b1, "R12");

        // R5 / R7: region 1, 64 KB, unaligned start 0x0001F000
        wr(8'hC7, 8'h00);
        wr(8'hC8, 8'h01);
        wr(8'hC9, 8'hF5);
        rd_check(8'hC9, 8'hF5, "R2");
        probe(32'h00010000, 1'b1, "R7");
        probe(32'h0001FFFF, 1'b1, "R5");
        probe(32'h00020000, 1'b0, "R7");
        probe(32'h0000FFFF, 1'b0, "R7");

        // R7: region 2, 32 MB at 0x42000000
        wr(8'hCA, 8'h42);
        wr(8'hCB, 8'h00);
        wr(8'hCC, 8'h0E);
        probe(32'h43FFFFFF, 1'b1, "R7");
        probe(32'h44000000, 1'b0, "R7");
        probe(32'h41FFFFFF, 1'b0, "R7");

        // R7: region 3, 4 KB at 0xFFFFF000
        wr(8'hCD, 8'hFF);
        wr(8'hCE, 8'hFF);
        wr(8'hCF, 8'hF1);
        probe(32'hFFFFFFFF, 1'b1, "R7");
        probe(32'hFFFFEFFF, 1'b0, "R7");

        // R8: code 15 covers everything
        wr(8'hCF, 8'h0F);
        probe(32'h00000000, 1'b1, "R8");
        probe(32'h89ABCDEF, 1'b1, "R8");
        wr(8'hCF, 8'h00);
        probe(32'h89ABCDEF, 1'b0, "R6");

        // clear regions 0..2 for window tests
        wr(8'hC6, 8'h00);
        wr(8'hC9, 8'h00);
        wr(8'hCC, 8'h00);

        // R9: first 64 KB of each 1 MB
        wr(8'hC0, 8'h01);
        probe(32'h00000000, 1'b1, "R9");
        probe(32'h0030FFFF, 1'b1, "R9");
        probe(32'h00310000, 1'b0, "R9");
        probe(32'h7FF0ABCD, 1'b1, "R9");
        probe(32'h000A0000, 1'b0, "R9");

        // R10: 640 KB .. 1 MB hole
        wr(8'hC0, 8'h02);
        probe(32'h0009FFFF, 1'b0, "R10");
        probe(32'h000A0000, 1'b1, "R10");
        probe(32'h000FFFFF, 1'b1, "R10");
        probe(32'h00100000, 1'b0, "R10");
        probe(32'h001A0000, 1'b0, "R10");
        probe(32'h00000000, 1'b0, "R10");

        // R11: OR of sources, one-cycle latency on alternating addresses
        wr(8'hC0, 8'h03);
        wr(8'hC6, 8'h43);
        probe(32'h12344000, 1'b1, "R11");
        probe(32'h00050000, 1'b0, "R11");
        probe(32'h00000000, 1'b1, "R11");
        probe(32'h00050000, 1'b0, "R11");
        probe(32'h000B0000, 1'b1, "R11");
        probe(32'h12348000, 1'b0, "R11");

        repeat (3) @(negedge clk);
        finish_run();
    end
endmodule